// File: doc/BRIEF.md
# Two-Lane Virtual-Channel Router Input Port

This block terminates one physical router input link and divides it into two virtual channels. Every arriving flit carries a one-bit channel tag and is written into that channel's own three-entry flit queue. The tag is the packet's message class: requests travel on one channel and replies on the other, so a request stalled for lack of downstream room can never hold up the reply that would free it.

On the output side a single physical link is shared. Each cycle a round-robin arbiter picks at most one channel whose queue is not empty and whose downstream credit counter is non-zero, and that channel's oldest flit leaves on the link. Credits are granted one flit at a time: each channel starts with three, loses one per departing flit and regains one per returned credit pulse. A channel with no credit is simply passed over, so traffic on the other channel keeps flowing.

Two kinds of state machine are used. The arbiter has states FAVOR_VC0 and FAVOR_VC1; a grant to channel 0 moves it to FAVOR_VC1 and a grant to channel 1 moves it to FAVOR_VC0, and it holds its state in a cycle with no grant. Each channel has a packet-ownership machine with states VC_IDLE and VC_HELD: a head flit without a tail leaving moves VC_IDLE to VC_HELD, and the tail flit leaving moves VC_HELD back to VC_IDLE. A write into a full queue is dropped and reported.

Top module: `vc_input_port`

## Requirements
- R1: After reset the output is idle, both overflow flags are low, each channel holds three credits and the arbiter is in FAVOR_VC0; so with no credit returned, exactly three flits can leave on each channel.
- R2: A flit written with tag v (0 = request class, 1 = reply class) leaves with out_vc equal to v and the same head, tail and data bits, in arrival order within that channel, at the earliest in the cycle after the write edge.
- R3: At most one flit leaves on the output link per cycle.
- R4: Flits on one channel leave while the other channel holds flits that are blocked for lack of credit.
- R5: A departing flit takes one credit from its channel and a credit_in pulse for that channel gives one back; a channel with zero credits sends nothing until a credit returns, and one returned credit releases exactly one flit.
- R6: When both channels are eligible in a cycle, the arbiter grants the channel it favours; after any grant the other channel is favoured, so under continuous contention the grants alternate 0,1,0,1.
- R7: Each queue holds three flits. A write to a queue that holds three flits and is not sending in the same cycle is dropped and raises that channel's bit of q_overflow for exactly the next cycle; a write to a full queue in the cycle it sends a flit is accepted without a flag.
- R8: Once a head flit leaves on a channel, that channel carries only the same packet until its tail flit leaves; a head flit is the first flit seen on a channel after reset or after a tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A flit is present on the input link |
| in_vc | input | 1 | Channel tag of the incoming flit (message class) |
| in_head | input | 1 | Incoming flit is the first of its packet |
| in_tail | input | 1 | Incoming flit is the last of its packet |
| in_data | input | FLIT_W | Incoming flit payload |
| credit_in | input | 2 | One credit returned per bit, bit v for channel v |
| out_valid | output | 1 | A flit leaves on the output link this cycle |
| out_vc | output | 1 | Channel of the departing flit |
| out_head | output | 1 | Departing flit is a head flit |
| out_tail | output | 1 | Departing flit is a tail flit |
| out_data | output | FLIT_W | Departing flit payload |
| q_overflow | output | 2 | One-cycle flag per channel: a write to a full queue was dropped |

## Verification
The assertions take for granted that the upstream sender frames packets properly per channel (a head opens a packet, a tail closes it, no head arrives inside an open packet) and that downstream never returns more credits than it has flits outstanding, so a counter is never pushed past three. The stimulus keeps within this by returning credits either in single deliberate pulses while a counter is below three, or automatically only in the cycle a flit of that channel leaves, and by writing only well-framed packets. The one write into a full queue is made on purpose and its dropped flit is never placed in the scoreboard, so a leak of it would be seen at the output.

// File: rtl/vcip_pkg.sv
package vcip_pkg;

    // Number of virtual channels sharing the link; the arbiter states assume two.
    localparam int VC_COUNT = 2;
    localparam int VC_IDX_W = 1;

    typedef enum logic {
        VC_IDLE = 1'b0,
        VC_HELD = 1'b1
    } vc_state_e;

    typedef enum logic {
        FAVOR_VC0 = 1'b0,
        FAVOR_VC1 = 1'b1
    } arb_state_e;

endpackage

// File: rtl/vcip_flit_queue.sv
module vcip_flit_queue #(
    parameter int WIDTH = 34,
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full,
    output logic             wr_drop
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;
    logic             accept;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign accept  = wr_en && (!full || rd_en);
    assign wr_drop = wr_en && !accept;
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept) wr_ptr <= ptr_inc(wr_ptr);
            if (rd_en)  rd_ptr <= ptr_inc(rd_ptr);
            unique case ({accept, rd_en})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2
    no_read_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);

    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

endmodule

// File: rtl/vcip_credit_ctr.sv
module vcip_credit_ctr #(
    parameter int MAX_CREDIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spend,
    input  logic refund,
    output logic avail
);
    localparam int CNT_W = $clog2(MAX_CREDIT + 1);

    logic [CNT_W-1:0] cnt;

    assign avail = (cnt != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CNT_W'(MAX_CREDIT);
        end else begin
            unique case ({spend, refund})
                2'b10:   cnt <= cnt - 1'b1;
                2'b01:   cnt <= cnt + 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R5
    spend_needs_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spend |-> (cnt != '0));

    // R5
    refund_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (refund && !spend) |-> (cnt < CNT_W'(MAX_CREDIT)));

endmodule

// File: rtl/vcip_rr_arb.sv
module vcip_rr_arb
    import vcip_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [VC_COUNT-1:0] req,
    output logic [VC_COUNT-1:0] grant
);
    arb_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FAVOR_VC0;
        else        state_q <= state_d;
    end

    always_comb begin
        grant   = '0;
        state_d = state_q;
        unique case (state_q)
            FAVOR_VC0: begin
                if (req[0])      grant = 2'b01;
                else if (req[1]) grant = 2'b10;
            end
            FAVOR_VC1: begin
                if (req[1])      grant = 2'b10;
                else if (req[0]) grant = 2'b01;
            end
        endcase
        if (grant[0])      state_d = FAVOR_VC1;
        else if (grant[1]) state_d = FAVOR_VC0;
    end

    // R3
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R6
    grant_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);

    // R6
    rr_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant[0] |=> (req[1] -> grant[1]));

endmodule

// File: rtl/vc_input_port.sv
module vc_input_port
    import vcip_pkg::*;
#(
    parameter int FLIT_W     = 32,
    parameter int Q_DEPTH    = 3,
    parameter int MAX_CREDIT = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_vc,
    input  logic                in_head,
    input  logic                in_tail,
    input  logic [FLIT_W-1:0]   in_data,
    input  logic [VC_COUNT-1:0] credit_in,
    output logic                out_valid,
    output logic                out_vc,
    output logic                out_head,
    output logic                out_tail,
    output logic [FLIT_W-1:0]   out_data,
    output logic [VC_COUNT-1:0] q_overflow
);
    localparam int ENTRY_W = FLIT_W + 2;

    logic [ENTRY_W-1:0]  head_entry [VC_COUNT];
    logic [VC_COUNT-1:0] q_empty, q_full, q_drop, credit_ok, req, grant;

    vcip_rr_arb u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .grant (grant)
    );

    for (genvar v = 0; v < VC_COUNT; v++) begin : g_vc
        logic      wr_en;
        vc_state_e own_q, own_d;

        assign wr_en  = in_valid && (in_vc == VC_IDX_W'(v));
        assign req[v] = !q_empty[v] && credit_ok[v];

        vcip_flit_queue #(.WIDTH(ENTRY_W), .DEPTH(Q_DEPTH)) u_queue (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_data ({in_head, in_tail, in_data}),
            .rd_en   (grant[v]),
            .rd_data (head_entry[v]),
            .empty   (q_empty[v]),
            .full    (q_full[v]),
            .wr_drop (q_drop[v])
        );

        vcip_credit_ctr #(.MAX_CREDIT(MAX_CREDIT)) u_credit (
            .clk    (clk),
            .rst_n  (rst_n),
            .spend  (grant[v]),
            .refund (credit_in[v]),
            .avail  (credit_ok[v])
        );

        // Packet ownership of the downstream channel.
        always_ff @(posedge clk) begin
            if (!rst_n) own_q <= VC_IDLE;
            else        own_q <= own_d;
        end

        always_comb begin
            own_d = own_q;
            unique case (own_q)
                VC_IDLE: if (grant[v] && head_entry[v][ENTRY_W-1] && !head_entry[v][ENTRY_W-2])
                             own_d = VC_HELD;
                VC_HELD: if (grant[v] && head_entry[v][ENTRY_W-2])
                             own_d = VC_IDLE;
            endcase
        end

        always_ff @(posedge clk) begin
            if (!rst_n) q_overflow[v] <= 1'b0;
            else        q_overflow[v] <= q_drop[v];
        end

        // R8
        held_no_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (own_q == VC_HELD && grant[v]) |-> !head_entry[v][ENTRY_W-1]);

        // R8
        idle_needs_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (own_q == VC_IDLE && grant[v]) |-> head_entry[v][ENTRY_W-1]);

        // R7
        full_write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && q_full[v] && !grant[v]) |=> q_overflow[v]);
    end

    always_comb begin
        out_valid = |grant;
        out_vc    = 1'b0;
        out_head  = 1'b0;
        out_tail  = 1'b0;
        out_data  = '0;
        for (int v = 0; v < VC_COUNT; v++) begin
            if (grant[v]) begin
                out_vc   = VC_IDX_W'(v);
                out_head = head_entry[v][ENTRY_W-1];
                out_tail = head_entry[v][ENTRY_W-2];
                out_data = head_entry[v][FLIT_W-1:0];
            end
        end
    end

    // R4
    blocked_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req[1] && !req[0]) |-> (out_valid && out_vc == 1'b1));

endmodule

// File: tb/vc_input_port_tb.sv
module vc_input_port_tb;
    localparam int FW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid, in_vc, in_head, in_tail;
    logic [FW-1:0] in_data;
    logic [1:0]    credit_in, manual_ret, auto_en;
    logic          out_valid, out_vc, out_head, out_tail;
    logic [FW-1:0] out_data;
    logic [1:0]    q_overflow;

    int checks   = 0;
    int failures = 0;

    logic [FW+1:0] expq0 [$];
    logic [FW+1:0] expq1 [$];
    bit            held [2];

    always #5 clk = ~clk;

    // Downstream model: manual pulses plus an automatic return for a departing flit.
    assign credit_in = manual_ret | (out_valid ? (auto_en & (2'b01 << out_vc)) : 2'b00);

    vc_input_port u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_vc      (in_vc),
        .in_head    (in_head),
        .in_tail    (in_tail),
        .in_data    (in_data),
        .credit_in  (credit_in),
        .out_valid  (out_valid),
        .out_vc     (out_vc),
        .out_head   (out_head),
        .out_tail   (out_tail),
        .out_data   (out_data),
        .q_overflow (q_overflow)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    endtask

    // Driver: one flit per call, expected entry goes to the scoreboard unless dropped.
    task automatic send_flit(input bit vc, input bit hd, input bit tl,
                             input logic [FW-1:0] d, input bit dropped = 1'b0);
        @(negedge clk);
        in_valid = 1'b1;
        in_vc    = vc;
        in_head  = hd;
        in_tail  = tl;
        in_data  = d;
        if (!dropped) begin
            if (vc) expq1.push_back({hd, tl, d});
            else    expq0.push_back({hd, tl, d});
        end
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: every departing flit must match the oldest expected one of its channel.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            logic [FW+1:0] exp_e;
            bit            have;
            have = out_vc ? (expq1.size() > 0) : (expq0.size() > 0);
            if (!have) begin
                check(1'b0, "R2", "unexpected flit", {30'd0, out_head, out_tail, out_data}, 64'd0);
            end else begin
                exp_e = out_vc ? expq1.pop_front() : expq0.pop_front();
                check({out_head, out_tail, out_data} == exp_e, "R2", "flit content",
                      {30'd0, out_head, out_tail, out_data}, {30'd0, exp_e});
            end
            // R8: head exactly when the channel is not held by a packet
            check(out_head == !held[out_vc], "R8", "head vs channel ownership",
                  64'(out_head), 64'(!held[out_vc]));
            if (out_tail)      held[out_vc] = 1'b0;
            else if (out_head) held[out_vc] = 1'b1;
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R1: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_vc = 1'b0; in_head = 1'b0; in_tail = 1'b0;
        in_data = '0; manual_ret = 2'b00; auto_en = 2'b00;
        held[0] = 1'b0; held[1] = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", 64'(out_valid), 64'd0);
        check(q_overflow == 2'b00, "R1", "q_overflow in reset", 64'(q_overflow), 64'd0);
        rst_n = 1'b1;

        // Phase A: three flits per channel use up the initial credits (R1, R2).
        send_flit(0, 1, 0, 32'h11);
        send_flit(0, 0, 0, 32'h12);
        send_flit(0, 0, 1, 32'h13);
        send_flit(1, 1, 0, 32'h21);
        send_flit(1, 0, 0, 32'h22);
        send_flit(1, 0, 1, 32'h23);
        idle();
        check(out_valid && out_vc == 1'b1, "R2", "last reply flit leaves", 64'(out_valid), 64'd1);
        idle();
        check(out_valid == 1'b0, "R1", "idle after drain", 64'(out_valid), 64'd0);

        // Phase B: no credit left, queues fill to three each (R1, R5).
        send_flit(0, 1, 0, 32'h31);
        send_flit(0, 0, 0, 32'h32);
        send_flit(0, 0, 1, 32'h33);
        send_flit(1, 1, 0, 32'h41);
        send_flit(1, 0, 0, 32'h42);
        send_flit(1, 0, 1, 32'h43);
        idle();
        check(out_valid == 1'b0, "R1", "fourth flit waits for credit", 64'(out_valid), 64'd0);
        check(q_overflow == 2'b00, "R7", "three flits fit", 64'(q_overflow), 64'd0);

        // Phase C: both eligible every cycle, grants alternate from channel 0 (R6, R3).
        manual_ret = 2'b11;
        idle();
        manual_ret = 2'b00;
        auto_en    = 2'b11;
        check(out_valid && out_vc == 1'b0, "R6", "first tie grant", 64'(out_vc), 64'd0);
        for (int k = 1; k < 6; k++) begin
            idle();
            check(out_valid == 1'b1, "R3", "one flit per cycle", 64'(out_valid), 64'd1);
            check(out_vc == k[0], "R6", "alternating grant", 64'(out_vc), 64'(k[0]));
        end
        idle();
        check(out_valid == 1'b0, "R3", "six flits took six cycles", 64'(out_valid), 64'd0);
        auto_en = 2'b00;

        // Phase D: request channel starved, reply channel passes it (R4, R5).
        send_flit(0, 1, 0, 32'h51);
        send_flit(0, 0, 0, 32'h52);
        send_flit(0, 0, 1, 32'h53);
        auto_en = 2'b10;
        send_flit(1, 1, 0, 32'h61);
        send_flit(1, 0, 1, 32'h62);
        check(out_valid && out_vc == 1'b1, "R4", "reply head passes blocked request", 64'(out_vc), 64'd1);
        idle();
        check(out_valid && out_vc == 1'b1, "R4", "reply tail passes blocked request", 64'(out_vc), 64'd1);
        idle();
        check(out_valid == 1'b0, "R5", "zero credit blocks request", 64'(out_valid), 64'd0);
        idle();
        manual_ret = 2'b01;
        idle();
        manual_ret = 2'b00;
        check(out_valid && out_vc == 1'b0, "R5", "returned credit releases a flit", 64'(out_valid), 64'd1);
        idle();
        check(out_valid == 1'b0, "R5", "one credit releases one flit", 64'(out_valid), 64'd0);
        manual_ret = 2'b01;
        idle();
        manual_ret = 2'b00;
        auto_en    = 2'b11;
        check(out_valid && out_vc == 1'b0, "R5", "tail after second credit", 64'(out_valid), 64'd1);
        idle();
        check(out_valid == 1'b0, "R5", "request channel drained", 64'(out_valid), 64'd0);
        auto_en = 2'b00;

        // Phase E: write to a full queue is dropped and flagged (R7).
        send_flit(1, 1, 1, 32'h71);
        send_flit(1, 1, 0, 32'h72);
        send_flit(1, 0, 0, 32'h73);
        send_flit(1, 0, 1, 32'h74);
        send_flit(1, 1, 1, 32'h75, 1'b1);
        idle();
        check(q_overflow == 2'b10, "R7", "overflow flag on reply channel", 64'(q_overflow), 64'h2);
        idle();
        check(q_overflow == 2'b00, "R7", "overflow flag lasts one cycle", 64'(q_overflow), 64'd0);

        // Full queue written in the cycle it sends: accepted, no flag (R7).
        send_flit(0, 1, 0, 32'h81);
        send_flit(0, 0, 0, 32'h82);
        send_flit(0, 0, 0, 32'h83);
        send_flit(0, 0, 0, 32'h84);
        idle();
        manual_ret = 2'b01;
        send_flit(0, 0, 1, 32'h85);
        manual_ret = 2'b00;
        idle();
        check(q_overflow == 2'b00, "R7", "write during send not flagged", 64'(q_overflow), 64'd0);

        idle();
        manual_ret = 2'b11;
        auto_en    = 2'b11;
        idle();
        manual_ret = 2'b00;
        repeat (14) idle();
        check(out_valid == 1'b0, "R7", "output idle after drain", 64'(out_valid), 64'd0);
        check(expq0.size() == 0, "R2", "request flits all delivered", 64'(expq0.size()), 64'd0);
        check(expq1.size() == 0, "R7", "reply flits delivered, dropped one absent",
              64'(expq1.size()), 64'd0);

        summary();
        $finish;
    end
endmodule